// File: doc/BRIEF.md
# Single-Precision Floating-Point Adder

This block adds or subtracts two 32-bit binary floating-point words. Each word holds a sign bit, an 8-bit exponent biased by 127, and a 23-bit fraction with an implied leading one. A control input turns the operation into subtraction by flipping the sign of the second operand. The datapath runs through these steps in order:

- unpack both operands and sort them by exponent;
- shift the smaller significand right, keeping the bits it loses as guard, round and sticky bits;
- add or subtract the significands;
- normalize the result in either direction;
- round to nearest even, renormalizing if the rounding carries out;
- pack the result word.

Infinities and NaNs are handled. Operands with a zero exponent field count as signed zeros. Results that underflow are flushed to signed zero. Two flags come out with the result: one for exponent overflow and one for the invalid case where opposite infinities meet.

Exponent and fraction widths are parameters, so the same code can build other binary formats. A parameter also selects whether the result is registered, which gives a latency of one cycle, or driven straight from the logic.

Top module: `fp_add_sp`

## Requirements
- R1: Two finite normal operands whose exact sum is representable produce that exact sum in the word layout: bit 31 sign, bits 30:23 exponent biased by 127, bits 22:0 fraction with a hidden 1.
- R2: The operand with the smaller exponent is aligned to the larger one before the add, whichever port it arrives on. An addend smaller than the result's rounding step by more than the whole extended significand width still only affects the sticky bit.
- R3: With sub_i=1 the result is opb_i subtracted from opa_i. When operands of differing effective sign give a negative raw difference, the result is its magnitude with the sign bit set.
- R4: A carry out of the significand sum shifts the result right one place and raises the exponent by one. Leading zeros after a subtraction shift it left and lower the exponent by the same count.
- R5: The result is rounded to nearest with ties to even. Below half an ulp it truncates. Above half it increments. At exactly half it increments only when the last kept fraction bit is 1.
- R6: A rounding increment that carries out of the significand raises the exponent by one and leaves the fraction zero.
- R7: Any NaN operand (exponent 255, fraction nonzero) produces 0x7FC00000 with both flags low.
- R8: Infinities of opposite effective sign produce 0x7FC00000 with inv_o=1.
- R9: An infinity (exponent 255, fraction 0) meeting a finite operand or a same-signed infinity produces that infinity with its effective sign and both flags low.
- R10: A finite result whose exponent reaches 255, before or after rounding, becomes infinity of the result sign with ovf_o=1. ovf_o and inv_o are never high together.
- R11: A difference of equal magnitudes gives +0 (0x00000000), including +0 combined with -0.
- R12: Operands with exponent field 0 are treated as zero of their sign, and two same-signed zeros keep that sign. A result whose normalized exponent is 0 or below becomes zero of the result sign.
- R13: With OUT_REG=1, reset (rst_n low) clears sum_o and both flags at once. Each result appears on the clock edge after its operands are sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous reset, active low |
| opa_i | input | 32 | First operand word |
| opb_i | input | 32 | Second operand word |
| sub_i | input | 1 | 1 subtracts opb_i from opa_i, 0 adds |
| sum_o | output | 32 | Result word |
| ovf_o | output | 1 | Result exponent overflowed to infinity |
| inv_o | output | 1 | Opposite infinities combined, result is NaN |

## Verification
The bench builds the block with its default parameters: 8-bit exponent, 23-bit fraction and the registered output. The registered output makes the one-cycle latency and the asynchronous clear observable at the ports, and it enables the next-cycle properties on NaN, cancellation and infinity pairs. At these widths the extended significand is 27 bits wide. Exponent gaps of 24 and 25 therefore land exactly on the guard and round positions, which lets exact ties, below-half and above-half cases be built on purpose. A gap of 30 pushes the whole addend past the sticky position. The largest finite value lets overflow be reached both by a carry from the sum and by a carry from rounding.

// File: rtl/fpadd_pkg.sv
package fpadd_pkg;
   // operand classification after unpacking
   typedef enum logic [1:0] {
      FC_ZERO = 2'd0,
      FC_NORM = 2'd1,
      FC_INF  = 2'd2,
      FC_NAN  = 2'd3
   } fcls_e;
endpackage

// File: rtl/fpadd_unpack.sv
module fpadd_unpack import fpadd_pkg::*; #(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23
) (
   input  logic [EXP_W+FRAC_W:0] word_i,
   input  logic                  neg_i,
   output logic                  sign_o,
   output logic [EXP_W-1:0]      exp_o,
   output logic [FRAC_W:0]       sig_o,
   output fcls_e                 cls_o
);
   localparam int W = 1 + EXP_W + FRAC_W;

   logic [EXP_W-1:0]  e_fld;
   logic [FRAC_W-1:0] f_fld;

   always_comb begin
      e_fld  = word_i[W-2:FRAC_W];
      f_fld  = word_i[FRAC_W-1:0];
      sign_o = word_i[W-1] ^ neg_i;
      exp_o  = e_fld;
      sig_o  = '0;
      if (e_fld == '0) begin
         cls_o = FC_ZERO;           // subnormals flushed here
         exp_o = '0;
      end else if (e_fld == '1) begin
         cls_o = (f_fld != '0) ? FC_NAN : FC_INF;
      end else begin
         cls_o = FC_NORM;
         sig_o = {1'b1, f_fld};
      end
   end
endmodule

// File: rtl/fpadd_align.sv
module fpadd_align #(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23
) (
   input  logic                sign_a_i,
   input  logic [EXP_W-1:0]    exp_a_i,
   input  logic [FRAC_W:0]     sig_a_i,
   input  logic                sign_b_i,
   input  logic [EXP_W-1:0]    exp_b_i,
   input  logic [FRAC_W:0]     sig_b_i,
   output logic                sign_big_o,
   output logic                sign_sml_o,
   output logic [EXP_W-1:0]    exp_big_o,
   output logic [FRAC_W+3:0]   ext_big_o,
   output logic [FRAC_W+3:0]   ext_sml_o
);
   localparam int SIG_W = FRAC_W + 1;
   localparam int EXT_W = SIG_W + 3;             // guard, round, sticky
   localparam int SH_W  = $clog2(EXT_W + 1);

   logic              b_wins;
   logic [EXP_W-1:0]  gap;
   logic [SH_W-1:0]   shamt;
   logic [SIG_W-1:0]  sig_sml;
   logic [EXT_W-1:0]  raw_sml;
   logic [EXT_W-1:0]  keep_mask;
   logic              lost;

   always_comb begin
      // swap on exponent only; equal exponents keep operand a on top
      b_wins     = exp_b_i > exp_a_i;
      sign_big_o = b_wins ? sign_b_i : sign_a_i;
      sign_sml_o = b_wins ? sign_a_i : sign_b_i;
      exp_big_o  = b_wins ? exp_b_i  : exp_a_i;
      ext_big_o  = {(b_wins ? sig_b_i : sig_a_i), 3'b000};
      sig_sml    = b_wins ? sig_a_i : sig_b_i;
      gap        = b_wins ? (exp_b_i - exp_a_i) : (exp_a_i - exp_b_i);
      if ({{(32-EXP_W){1'b0}}, gap} > 32'(EXT_W))
         shamt = SH_W'(EXT_W);
      else
         shamt = SH_W'(gap);
      raw_sml   = {sig_sml, 3'b000};
      keep_mask = ~({EXT_W{1'b1}} << shamt);
      lost      = |(raw_sml & keep_mask);
      ext_sml_o = (raw_sml >> shamt) | {{(EXT_W-1){1'b0}}, lost};
   end
endmodule

// File: rtl/fpadd_normround.sv
module fpadd_normround #(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23
) (
   input  logic                  eff_sub_i,
   input  logic                  sign_big_i,
   input  logic [EXP_W-1:0]      exp_big_i,
   input  logic [FRAC_W+3:0]     ext_big_i,
   input  logic [FRAC_W+3:0]     ext_sml_i,
   output logic [EXP_W+FRAC_W:0] word_o,
   output logic                  ovf_o
);
   localparam int SIG_W = FRAC_W + 1;
   localparam int EXT_W = SIG_W + 3;
   localparam int N     = EXT_W + 1;             // carry position added
   localparam int LZ_W  = $clog2(N + 1);
   localparam int EI_W  = EXP_W + 2;
   localparam logic signed [EI_W-1:0] EMAX_S = EI_W'((2 ** EXP_W) - 1);

   logic [N-1:0]              addend, raw, mag, lshift;
   logic                      neg, r_sign;
   logic [LZ_W-1:0]           lz;
   logic [EXT_W-1:0]          norm;
   logic signed [EI_W-1:0]    e_n, e_r;
   logic                      rnd, stk, lsb, inc;
   logic [SIG_W:0]            sig_r;

   always_comb begin
      addend = eff_sub_i ? (~{1'b0, ext_sml_i} + N'(1)) : {1'b0, ext_sml_i};
      raw    = {1'b0, ext_big_i} + addend;
      neg    = eff_sub_i & raw[N-1];
      mag    = neg ? (~raw + N'(1)) : raw;
      r_sign = sign_big_i ^ neg;

      // leading-zero count: highest set bit wins
      lz = LZ_W'(N);
      for (int i = 0; i < N; i++)
         if (mag[i]) lz = LZ_W'(N - 1 - i);

      lshift = '0;
      if (mag[N-1]) begin
         norm = mag[N-1:1] | {{(EXT_W-1){1'b0}}, mag[0]};
         e_n  = $signed({2'b00, exp_big_i}) + EI_W'(1);
      end else begin
         lshift = mag << (lz - LZ_W'(1));
         norm   = lshift[N-2:0];
         e_n    = $signed({2'b00, exp_big_i})
                  - $signed({{(EI_W-LZ_W){1'b0}}, lz}) + EI_W'(1);
      end

      rnd   = norm[2];
      stk   = norm[1] | norm[0];
      lsb   = norm[3];
      inc   = rnd & (stk | lsb);
      sig_r = {1'b0, norm[EXT_W-1:3]} + {{SIG_W{1'b0}}, inc};
      e_r   = e_n + $signed({{(EI_W-1){1'b0}}, sig_r[SIG_W]});

      ovf_o = 1'b0;
      if (mag == '0) begin
         word_o = {~eff_sub_i & sign_big_i, {(EXP_W+FRAC_W){1'b0}}};
      end else if (e_n <= 0) begin
         word_o = {r_sign, {(EXP_W+FRAC_W){1'b0}}};
      end else if (e_r >= EMAX_S) begin
         word_o = {r_sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
         ovf_o  = 1'b1;
      end else begin
         word_o = {r_sign, e_r[EXP_W-1:0], sig_r[FRAC_W-1:0]};
      end
   end
endmodule

// File: rtl/fp_add_sp.sv
module fp_add_sp import fpadd_pkg::*; #(
   parameter int EXP_W   = 8,
   parameter int FRAC_W  = 23,
   parameter int OUT_REG = 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [EXP_W+FRAC_W:0] opa_i,
   input  logic [EXP_W+FRAC_W:0] opb_i,
   input  logic                  sub_i,
   output logic [EXP_W+FRAC_W:0] sum_o,
   output logic                  ovf_o,
   output logic                  inv_o
);
   localparam int W     = 1 + EXP_W + FRAC_W;
   localparam int SIG_W = FRAC_W + 1;
   localparam int EXT_W = SIG_W + 3;
   localparam logic [W-1:0] QNAN    = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
   localparam logic [W-2:0] INF_MAG = {{EXP_W{1'b1}}, {FRAC_W{1'b0}}};

   if (EXP_W < 3 || EXP_W > 16 || FRAC_W < 2 || FRAC_W > 112) begin : g_bad_width
      $error("fp_add_sp: unsupported EXP_W/FRAC_W");
   end
   if (OUT_REG != 0 && OUT_REG != 1) begin : g_bad_outreg
      $error("fp_add_sp: OUT_REG must be 0 or 1");
   end

   logic [1:0][W-1:0]  ops;
   logic [1:0]         sgn;
   logic [EXP_W-1:0]   ex  [2];
   logic [SIG_W-1:0]   sig [2];
   fcls_e              cl  [2];

   assign ops = {opb_i, opa_i};

   for (genvar k = 0; k < 2; k++) begin : g_unp
      fpadd_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unp (
         .word_i (ops[k]),
         .neg_i  ((k == 1) ? sub_i : 1'b0),
         .sign_o (sgn[k]),
         .exp_o  (ex[k]),
         .sig_o  (sig[k]),
         .cls_o  (cl[k])
      );
   end

   logic                sign_big, sign_sml;
   logic [EXP_W-1:0]    exp_big;
   logic [EXT_W-1:0]    ext_big, ext_sml;
   logic [W-1:0]        fin_word;
   logic                fin_ovf;

   fpadd_align #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_align (
      .sign_a_i   (sgn[0]),
      .exp_a_i    (ex[0]),
      .sig_a_i    (sig[0]),
      .sign_b_i   (sgn[1]),
      .exp_b_i    (ex[1]),
      .sig_b_i    (sig[1]),
      .sign_big_o (sign_big),
      .sign_sml_o (sign_sml),
      .exp_big_o  (exp_big),
      .ext_big_o  (ext_big),
      .ext_sml_o  (ext_sml)
   );

   fpadd_normround #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_nr (
      .eff_sub_i  (sign_big ^ sign_sml),
      .sign_big_i (sign_big),
      .exp_big_i  (exp_big),
      .ext_big_i  (ext_big),
      .ext_sml_i  (ext_sml),
      .word_o     (fin_word),
      .ovf_o      (fin_ovf)
   );

   logic [W-1:0] nxt_sum;
   logic         nxt_ovf, nxt_inv;
   logic         any_nan, inf_clash;

   always_comb begin
      any_nan   = (cl[0] == FC_NAN) || (cl[1] == FC_NAN);
      inf_clash = (cl[0] == FC_INF) && (cl[1] == FC_INF) && (sgn[0] != sgn[1]);
      nxt_ovf   = 1'b0;
      nxt_inv   = 1'b0;
      if (any_nan) begin
         nxt_sum = QNAN;
      end else if (inf_clash) begin
         nxt_sum = QNAN;
         nxt_inv = 1'b1;
      end else if (cl[0] == FC_INF) begin
         nxt_sum = {sgn[0], INF_MAG};
      end else if (cl[1] == FC_INF) begin
         nxt_sum = {sgn[1], INF_MAG};
      end else begin
         nxt_sum = fin_word;
         nxt_ovf = fin_ovf;
      end
   end

   if (OUT_REG == 1) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sum_o <= '0;
            ovf_o <= 1'b0;
            inv_o <= 1'b0;
         end else begin
            sum_o <= nxt_sum;
            ovf_o <= nxt_ovf;
            inv_o <= nxt_inv;
         end
      end

      assert_nan_prop_R7: assert property (@(posedge clk) disable iff (!rst_n)
         ((cl[0] == FC_NAN) || (cl[1] == FC_NAN)) |=> (sum_o == QNAN && !inv_o && !ovf_o));
      assert_inf_clash_R8: assert property (@(posedge clk) disable iff (!rst_n)
         (cl[0] == FC_INF && cl[1] == FC_INF && sgn[0] != sgn[1]) |=> inv_o);
      assert_cancel_R11: assert property (@(posedge clk) disable iff (!rst_n)
         (sub_i && opa_i == opb_i && cl[0] == FC_NORM) |=> (sum_o == '0 && !ovf_o));
   end else begin : g_comb
      assign sum_o = nxt_sum;
      assign ovf_o = nxt_ovf;
      assign inv_o = nxt_inv;
   end

   assert_ovf_is_inf_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_o |-> (sum_o[W-2:0] == INF_MAG));
   assert_flags_mutex_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(ovf_o && inv_o));
   assert_inv_is_qnan_R8: assert property (@(posedge clk) disable iff (!rst_n)
      inv_o |-> (sum_o == QNAN));
endmodule

// File: tb/fp_add_sp_test.sv
module fp_add_sp_test;
   localparam int CLK_PERIOD = 10;
   localparam int NV = 38;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] opa = '0, opb = '0;
   logic        sub = 1'b0;
   logic [31:0] sum;
   logic        ovf, inv;
   int          n_run = 0;
   int          n_fail = 0;
   bit          done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   fp_add_sp uut (
      .clk(clk), .rst_n(rst_n), .opa_i(opa), .opb_i(opb), .sub_i(sub),
      .sum_o(sum), .ovf_o(ovf), .inv_o(inv)
   );

   // {a, b, sub, expected, ovf, inv, requirement}
   localparam logic [106:0] VEC [NV] = '{
      // R1 exact sums
      {32'h40A00000, 32'h40400000, 1'b0, 32'h41000000, 1'b0, 1'b0, 8'd1},
      {32'hBE200000, 32'hBE200000, 1'b0, 32'hBEA00000, 1'b0, 1'b0, 8'd1},
      {32'h3F800000, 32'h3F800000, 1'b0, 32'h40000000, 1'b0, 1'b0, 8'd1},
      // R2 alignment, either port, far gap
      {32'h3F800000, 32'h3E800000, 1'b0, 32'h3FA00000, 1'b0, 1'b0, 8'd2},
      {32'h3E800000, 32'h3F800000, 1'b0, 32'h3FA00000, 1'b0, 1'b0, 8'd2},
      {32'h3F800000, 32'h30800000, 1'b0, 32'h3F800000, 1'b0, 1'b0, 8'd2},
      // R3 subtraction and negative difference
      {32'h40400000, 32'h3F800000, 1'b1, 32'h40000000, 1'b0, 1'b0, 8'd3},
      {32'h3F800000, 32'h40400000, 1'b1, 32'hC0000000, 1'b0, 1'b0, 8'd3},
      {32'h3F800000, 32'hBF800000, 1'b1, 32'h40000000, 1'b0, 1'b0, 8'd3},
      {32'h3F800000, 32'h3FC00000, 1'b1, 32'hBF000000, 1'b0, 1'b0, 8'd3},
      // R4 carry and leading-zero normalization
      {32'h3FC00000, 32'h3FC00000, 1'b0, 32'h40400000, 1'b0, 1'b0, 8'd4},
      {32'h3FC00000, 32'h3FA00000, 1'b1, 32'h3E800000, 1'b0, 1'b0, 8'd4},
      // R5 nearest-even rounding
      {32'h3F800000, 32'h33800000, 1'b0, 32'h3F800000, 1'b0, 1'b0, 8'd5},
      {32'h3F800000, 32'h33C00000, 1'b0, 32'h3F800001, 1'b0, 1'b0, 8'd5},
      {32'h3F800001, 32'h33800000, 1'b0, 32'h3F800002, 1'b0, 1'b0, 8'd5},
      {32'h3F800000, 32'h33000000, 1'b0, 32'h3F800000, 1'b0, 1'b0, 8'd5},
      {32'h3F800000, 32'h33C00000, 1'b1, 32'h3F7FFFFE, 1'b0, 1'b0, 8'd5},
      // R6 rounding carry
      {32'h3FFFFFFF, 32'h33800000, 1'b0, 32'h40000000, 1'b0, 1'b0, 8'd6},
      // R7 NaN inputs
      {32'h7FC00000, 32'h3F800000, 1'b0, 32'h7FC00000, 1'b0, 1'b0, 8'd7},
      {32'h3F800000, 32'hFF800001, 1'b0, 32'h7FC00000, 1'b0, 1'b0, 8'd7},
      {32'h7F800000, 32'h7FA00000, 1'b0, 32'h7FC00000, 1'b0, 1'b0, 8'd7},
      // R8 opposite infinities
      {32'h7F800000, 32'hFF800000, 1'b0, 32'h7FC00000, 1'b0, 1'b1, 8'd8},
      {32'h7F800000, 32'h7F800000, 1'b1, 32'h7FC00000, 1'b0, 1'b1, 8'd8},
      // R9 infinity passes through
      {32'h7F800000, 32'hC2000000, 1'b0, 32'h7F800000, 1'b0, 1'b0, 8'd9},
      {32'h3F800000, 32'h7F800000, 1'b1, 32'hFF800000, 1'b0, 1'b0, 8'd9},
      {32'h7F800000, 32'h7F800000, 1'b0, 32'h7F800000, 1'b0, 1'b0, 8'd9},
      // R10 overflow by sum carry and by rounding carry
      {32'h7F7FFFFF, 32'h7F7FFFFF, 1'b0, 32'h7F800000, 1'b1, 1'b0, 8'd10},
      {32'hFF7FFFFF, 32'hFF7FFFFF, 1'b0, 32'hFF800000, 1'b1, 1'b0, 8'd10},
      {32'h7F7FFFFF, 32'h73000000, 1'b0, 32'h7F800000, 1'b1, 1'b0, 8'd10},
      // R11 exact cancellation
      {32'h40400000, 32'h40400000, 1'b1, 32'h00000000, 1'b0, 1'b0, 8'd11},
      {32'hC0400000, 32'h40400000, 1'b0, 32'h00000000, 1'b0, 1'b0, 8'd11},
      {32'h00000000, 32'h80000000, 1'b0, 32'h00000000, 1'b0, 1'b0, 8'd11},
      // R12 zero exponent inputs and underflow flush
      {32'h00000001, 32'h3F800000, 1'b0, 32'h3F800000, 1'b0, 1'b0, 8'd12},
      {32'h80400000, 32'h80000001, 1'b0, 32'h80000000, 1'b0, 1'b0, 8'd12},
      {32'h00800000, 32'h00800001, 1'b1, 32'h80000000, 1'b0, 1'b0, 8'd12},
      {32'h00800001, 32'h00800000, 1'b1, 32'h00000000, 1'b0, 1'b0, 8'd12},
      {32'h80000000, 32'h3F800000, 1'b0, 32'h3F800000, 1'b0, 1'b0, 8'd12},
      {32'h80000000, 32'h80000000, 1'b0, 32'h80000000, 1'b0, 1'b0, 8'd12}
   };

   task automatic check(input int req, input logic [31:0] ey, input logic eo, input logic ei);
      n_run++;
      if (sum !== ey || ovf !== eo || inv !== ei) begin
         n_fail++;
         $display("FAIL R%0d: got %h ovf=%b inv=%b, expected %h ovf=%b inv=%b (a=%h b=%h sub=%b)",
                  req, sum, ovf, inv, ey, eo, ei, opa, opb, sub);
      end
   endtask

   task automatic apply(input logic [31:0] a, input logic [31:0] b, input logic s);
      @(negedge clk);
      opa = a; opb = b; sub = s;
      @(negedge clk);
   endtask

   initial begin
      // R13: outputs held clear while reset is low, even with live inputs
      opa = 32'h3F800000; opb = 32'h3F800000; sub = 1'b0;
      repeat (3) @(negedge clk);
      check(13, 32'h0, 1'b0, 1'b0);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         apply(VEC[i][106:75], VEC[i][74:43], VEC[i][42]);
         check(int'(VEC[i][7:0]), VEC[i][41:10], VEC[i][9], VEC[i][8]);
      end

      // R13: one-cycle latency, old result held until the next edge
      apply(32'h40A00000, 32'h40400000, 1'b0);
      @(negedge clk);
      opa = 32'h3F800000; opb = 32'h3E800000;
      #1 check(13, 32'h41000000, 1'b0, 1'b0);
      @(negedge clk);
      check(13, 32'h3FA00000, 1'b0, 1'b0);

      // R13: asynchronous clear mid-stream, flag included
      apply(32'h7F7FFFFF, 32'h7F7FFFFF, 1'b0);
      check(10, 32'h7F800000, 1'b1, 1'b0);
      #1 rst_n = 1'b0;
      #1 check(13, 32'h0, 1'b0, 1'b0);
      @(negedge clk);
      rst_n = 1'b1;

      // R8 after reset release: invalid result from subtracting equal infinities
      apply(32'hFF800000, 32'hFF800000, 1'b1);
      check(8, 32'h7FC00000, 1'b0, 1'b1);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: got timeout, expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule